// File: doc/BRIEF.md
# Finite-Field Transform Convolution Channel

This block computes the cyclic convolution of one segment of residues with a fixed short filter, entirely inside the prime field GF(MOD). It serves one residue lane of a filter built on a residue number system. Each lane owns a different prime of the form q·2^LOG_N + 1, which guarantees a root of unity of order 2^LOG_N. The segment length is N = 2^LOG_N, and the filter has N/2 taps. The caller zero-fills the upper half of every segment, so the cyclic result equals the linear convolution of the lower half with the taps. Conversion into and out of residues and the stitching of successive segments are left to neighbouring blocks.

A segment of N residues arrives as one flat word under a valid/ready handshake. Internally the block reorders the samples by bit reversal and runs a forward transform on a single radix-2 butterfly. The twiddles are integer powers of γ = OMEGA^((MOD-1)/N). It then multiplies every spectral point by the matching point of the tap spectrum. That spectrum is derived at elaboration from the tap parameter and held as a constant table. An inverse transform with γ⁻¹ follows, and finally every point is scaled by N⁻¹. All sums, differences and products are reduced modulo MOD, so the result is exact. The default configuration is LOG_N = 3, MOD = 41, OMEGA = 6 and 6-bit residues, with taps 1, 2, 3, 4.

Top module: `ntt_conv_channel`

## Requirements
- R1: After reset, inReady is 1 and outValid is 0.
- R2: Lane k of outSeg (bits [k*W +: W]) equals the sum over n of x[n]·h[(k−n) mod N], reduced mod MOD. Here x[n] is lane n of the accepted inSeg, h[m] is tap m of TAP_VEC (bits [m*W +: W]) for m < N/2, and h[m] is 0 otherwise.
- R3: When lanes N/2 to N−1 of the input are zero, lanes 0 to N−2 of the output equal the linear convolution of the lower half with the taps, and lane N−1 is 0.
- R4: Every output lane is below MOD, including the case where all inputs equal MOD−1.
- R5: inReady is 0 from the cycle after an accepted segment until the result has been taken. inValid and inSeg applied during that time have no effect on the result.
- R6: outValid rises exactly LOG_N·N + 2·N + 1 clock edges after the accepting edge, which is 41 edges by default.
- R7: While outValid is 1 and outReady is 0, outValid stays 1 and outSeg holds its value.
- R8: After the edge on which outValid and outReady are both 1, outValid is 0 and inReady is 1. A new segment can then be accepted on the next edge.
- R9: An all-zero segment yields all zeros. A unit impulse in lane 0 yields the taps in lanes 0 to N/2−1, followed by zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input segment offered |
| inReady | output | 1 | Block idle and able to take a segment |
| inSeg | input | N*W | Input residues, lane k at bits [k*W +: W] |
| outValid | output | 1 | Result segment available |
| outReady | input | 1 | Consumer takes the result |
| outSeg | output | N*W | Result residues, lane k at bits [k*W +: W] |

## Verification
There is one result per accepted segment. It is due exactly 41 edges after the accepting edge: 12 forward butterflies, 8 spectral products, 1 reorder, 12 inverse butterflies and 8 scaling products. The bench drives and samples on falling edges and counts the edges from acceptance to the rise of outValid against that figure. It compares all lanes only in that cycle, and compares them again after deliberately withheld outReady cycles. The handshake responses are checked one falling edge after the edge on which they take effect: inReady dropping after acceptance, and inReady returning after the result is taken.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FWD, ST_MUL, ST_PERM, ST_INV, ST_SCALE, ST_DONE
  } nttState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // capture input segment in bit-reversed order
    logic bfly;    // perform one radix-2 butterfly
    logic invDir;  // use inverse twiddles
    logic pmul;    // point-wise product at idx
    logic scale;   // product factor is N^-1 instead of tap spectrum
    logic perm;    // bit-reverse the whole register file
  } nttStrobe_t;

  function automatic int modPow(int base, int e, int m);
    int r;
    int b;
    r = 1;
    b = base % m;
    for (int i = 0; i < 31; i++) begin
      if (((e >> i) & 1) == 1) r = (r * b) % m;
      b = (b * b) % m;
    end
    return r;
  endfunction

  function automatic int bitRev(int v, int bits);
    int r;
    r = 0;
    for (int i = 0; i < bits; i++) r = (r << 1) | ((v >> i) & 1);
    return r;
  endfunction

endpackage

// File: rtl/ntt_control.sv
module ntt_control
  import ntt_pkg::*;
#(
  parameter int LOG_N = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic                      outReady,
  output logic                      inReady,
  output logic                      outValid,
  output nttStrobe_t                strb,
  output logic [$clog2(LOG_N)-1:0]  stage,
  output logic [LOG_N-1:0]          idx
);
  localparam int N    = 1 << LOG_N;
  localparam int HALF = N / 2;
  localparam int SW   = $clog2(LOG_N);

  nttState_e state;
  logic      lastBfly;
  logic      lastPoint;
  logic      lastStage;

  assign lastBfly  = (idx == LOG_N'(HALF - 1));
  assign lastPoint = (idx == LOG_N'(N - 1));
  assign lastStage = (stage == SW'(LOG_N - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      stage <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (inValid) begin
          state <= ST_FWD;
          idx   <= '0;
          stage <= '0;
        end
        ST_FWD, ST_INV: begin
          if (lastBfly) begin
            idx <= '0;
            if (lastStage) begin
              stage <= '0;
              state <= (state == ST_FWD) ? ST_MUL : ST_SCALE;
            end else begin
              stage <= stage + 1'b1;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_MUL, ST_SCALE: begin
          if (lastPoint) begin
            idx   <= '0;
            state <= (state == ST_MUL) ? ST_PERM : ST_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PERM: state <= ST_INV;
        ST_DONE: if (outReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.load   = (state == ST_IDLE) && inValid;
    strb.bfly   = (state == ST_FWD) || (state == ST_INV);
    strb.invDir = (state == ST_INV);
    strb.pmul   = (state == ST_MUL) || (state == ST_SCALE);
    strb.scale  = (state == ST_SCALE);
    strb.perm   = (state == ST_PERM);
  end

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_DONE);

endmodule

// File: rtl/ntt_datapath.sv
module ntt_datapath
  import ntt_pkg::*;
#(
  parameter int LOG_N = 3,
  parameter int W     = 6,
  parameter int MOD   = 41,
  parameter int OMEGA = 6,
  parameter logic [(1 << (LOG_N - 1))*W-1:0] TAP_VEC = {6'd4, 6'd3, 6'd2, 6'd1}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  nttStrobe_t                strb,
  input  logic [$clog2(LOG_N)-1:0]  stage,
  input  logic [LOG_N-1:0]          idx,
  input  logic [(1 << LOG_N)*W-1:0] inSeg,
  output logic [(1 << LOG_N)*W-1:0] outSeg
);
  localparam int N         = 1 << LOG_N;
  localparam int HALF      = N / 2;
  localparam int TW        = (LOG_N > 1) ? LOG_N - 1 : 1;
  localparam int GAMMA     = modPow(OMEGA, (MOD - 1) >> LOG_N, MOD);
  localparam int GAMMA_INV = modPow(GAMMA, MOD - 2, MOD);
  localparam int N_INV     = modPow(N % MOD, MOD - 2, MOD);

  // Tap spectrum point k: sum of h[n] * gamma^(n*k).
  function automatic int specAt(int k);
    int acc;
    acc = 0;
    for (int n = 0; n < HALF; n++)
      acc = (acc + int'(TAP_VEC[n*W +: W]) * modPow(GAMMA, (n * k) % N, MOD)) % MOD;
    return acc;
  endfunction

  logic [W-1:0] regs   [N];
  logic [W-1:0] twFwd  [HALF];
  logic [W-1:0] twInv  [HALF];
  logic [W-1:0] specRom[N];

  for (genvar k = 0; k < HALF; k++) begin : g_twiddle
    localparam int FWD_VAL = modPow(GAMMA, k, MOD);
    localparam int INV_VAL = modPow(GAMMA_INV, k, MOD);
    assign twFwd[k] = W'(FWD_VAL);
    assign twInv[k] = W'(INV_VAL);
  end

  for (genvar k = 0; k < N; k++) begin : g_spec
    localparam int SPEC_VAL = specAt(k);
    assign specRom[k] = W'(SPEC_VAL);
    assign outSeg[k*W +: W] = regs[k];
  end

  // Butterfly addressing.
  int              spanW;
  int              grpW;
  int              posW;
  logic [LOG_N-1:0] topIdx;
  logic [LOG_N-1:0] botIdx;
  logic [TW-1:0]    twSel;

  always_comb begin
    spanW  = 1 << stage;
    grpW   = int'(idx[TW-1:0]) >> stage;
    posW   = int'(idx[TW-1:0]) & (spanW - 1);
    topIdx = LOG_N'(grpW * 2 * spanW + posW);
    botIdx = LOG_N'(grpW * 2 * spanW + posW + spanW);
    twSel  = TW'(posW << (LOG_N - 1 - int'(stage)));
  end

  // Modular arithmetic.
  logic [W-1:0] twVal;
  logic [W-1:0] factor;
  int           prodBf;
  int           sumV;
  int           difV;
  int           prodPt;

  always_comb begin
    twVal  = strb.invDir ? twInv[twSel] : twFwd[twSel];
    prodBf = (int'(regs[botIdx]) * int'(twVal)) % MOD;
    sumV   = int'(regs[topIdx]) + prodBf;
    if (sumV >= MOD) sumV = sumV - MOD;
    difV   = int'(regs[topIdx]) - prodBf;
    if (difV < 0) difV = difV + MOD;
    factor = strb.scale ? W'(N_INV) : specRom[idx];
    prodPt = (int'(regs[idx]) * int'(factor)) % MOD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < N; k++) regs[k] <= '0;
    end else if (strb.load) begin
      for (int k = 0; k < N; k++) regs[k] <= inSeg[bitRev(k, LOG_N)*W +: W];
    end else if (strb.bfly) begin
      regs[topIdx] <= W'(sumV);
      regs[botIdx] <= W'(difV);
    end else if (strb.pmul) begin
      regs[idx] <= W'(prodPt);
    end else if (strb.perm) begin
      for (int k = 0; k < N; k++) regs[k] <= regs[bitRev(k, LOG_N)];
    end
  end

endmodule

// File: rtl/ntt_conv_channel.sv
module ntt_conv_channel
  import ntt_pkg::*;
#(
  parameter int LOG_N = 3,
  parameter int W     = 6,
  parameter int MOD   = 41,
  parameter int OMEGA = 6,
  parameter logic [(1 << (LOG_N - 1))*W-1:0] TAP_VEC = {6'd4, 6'd3, 6'd2, 6'd1}
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [(1 << LOG_N)*W-1:0] inSeg,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [(1 << LOG_N)*W-1:0] outSeg
);
  localparam int SW = $clog2(LOG_N);

  nttStrobe_t       strb;
  logic [SW-1:0]    stage;
  logic [LOG_N-1:0] idx;

  ntt_control #(.LOG_N(LOG_N)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strb(strb), .stage(stage), .idx(idx)
  );

  ntt_datapath #(
    .LOG_N(LOG_N), .W(W), .MOD(MOD), .OMEGA(OMEGA), .TAP_VEC(TAP_VEC)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .stage(stage), .idx(idx),
    .inSeg(inSeg), .outSeg(outSeg)
  );

endmodule

// File: rtl/ntt_conv_checker.sv
module ntt_conv_checker #(
  parameter int LOG_N = 3,
  parameter int W     = 6,
  parameter int MOD   = 41
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inValid,
  input logic                      inReady,
  input logic                      outValid,
  input logic                      outReady,
  input logic [(1 << LOG_N)*W-1:0] outSeg
);
  localparam int N       = 1 << LOG_N;
  localparam int LATENCY = LOG_N * N + 2 * N + 1;

  logic [15:0] busyCycles;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCycles <= '0;
    else if (inValid && inReady) busyCycles <= '0;
    else if (!inReady && !outValid && busyCycles != 16'hFFFF) busyCycles <= busyCycles + 1'b1;
  end

  assert_ready_valid_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (busyCycles == 16'(LATENCY)));

  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outSeg)));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (inReady && !outValid));

  for (genvar k = 0; k < N; k++) begin : g_lane
    assert_lane_range_R4: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (int'(outSeg[k*W +: W]) < MOD));
  end

endmodule

bind ntt_conv_channel ntt_conv_checker #(.LOG_N(LOG_N), .W(W), .MOD(MOD)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outSeg(outSeg)
);

// File: tb/sim_ntt_conv_channel.sv
`timescale 1ns/1ps
module sim_ntt_conv_channel;
  localparam int LOG_N = 3;
  localparam int N     = 8;
  localparam int W     = 6;
  localparam int P     = 41;
  localparam int LAT   = 41;
  localparam int TAPS[4] = '{1, 2, 3, 4};

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0;
  logic inReady;
  logic [N*W-1:0] inSeg = '0;
  logic outValid;
  logic outReady = 0;
  logic [N*W-1:0] outSeg;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ntt_conv_channel u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inSeg(inSeg),
    .outValid(outValid), .outReady(outReady), .outSeg(outSeg)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] refConv(input logic [N*W-1:0] x);
    logic [N*W-1:0] r;
    for (int k = 0; k < N; k++) begin
      int acc = 0;
      for (int n = 0; n < N; n++) begin
        int m = (k - n + N) % N;
        int h = (m < 4) ? TAPS[m] : 0;
        acc = (acc + int'(x[n*W +: W]) * h) % P;
      end
      r[k*W +: W] = W'(acc);
    end
    return r;
  endfunction

  task automatic checkLanes(input logic [N*W-1:0] exp, input string req);
    for (int k = 0; k < N; k++) begin
      check(outSeg[k*W +: W] == exp[k*W +: W], req, $sformatf("lane %0d", k),
            int'(outSeg[k*W +: W]), int'(exp[k*W +: W]));
      check(int'(outSeg[k*W +: W]) < P, "R4", $sformatf("range lane %0d", k),
            int'(outSeg[k*W +: W]), P - 1);
    end
  endtask

  // Sends one segment, checks latency and lanes, optionally pokes input while
  // busy and withholds outReady, then takes the result.
  task automatic runSeg(input logic [N*W-1:0] x, input logic [N*W-1:0] exp,
                        input string req, input bit poke, input int hold);
    int n;
    @(negedge clk);
    check(inReady == 1'b1, "R8", "ready before send", int'(inReady), 1);
    inSeg = x;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R5", "ready after accept", int'(inReady), 0);
    n = 0;
    while (!outValid && n < 200) begin
      if (poke && n == 5) begin
        inSeg = ~x;
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    inValid = 1'b0;
    check(n == LAT, "R6", "edges to result", n, LAT);
    checkLanes(exp, req);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(outValid == 1'b1, "R7", "valid held", int'(outValid), 1);
    end
    if (hold > 0) checkLanes(exp, "R7");
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    check(outValid == 1'b0, "R8", "valid after take", int'(outValid), 0);
    check(inReady == 1'b1, "R8", "ready after take", int'(inReady), 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(inReady == 1'b1, "R1", "reset inReady", int'(inReady), 1);
    check(outValid == 1'b0, "R1", "reset outValid", int'(outValid), 0);
  endtask

  task automatic testImpulseAndZero();
    logic [N*W-1:0] x = '0;
    logic [N*W-1:0] e = '0;
    runSeg(x, e, "R9", 1'b0, 0);
    x[0 +: W] = 6'd1;
    for (int k = 0; k < 4; k++) e[k*W +: W] = W'(TAPS[k]);
    runSeg(x, e, "R9", 1'b0, 0);
  endtask

  task automatic testLinear();
    for (int t = 0; t < 4; t++) begin
      logic [N*W-1:0] x = '0;
      logic [N*W-1:0] e = '0;
      for (int k = 0; k < 4; k++) x[k*W +: W] = W'($urandom_range(P - 1, 0));
      for (int k = 0; k < N; k++) begin
        int acc = 0;
        for (int n = 0; n < 4; n++)
          if (k - n >= 0 && k - n < 4) acc += int'(x[n*W +: W]) * TAPS[k - n];
        e[k*W +: W] = W'(acc % P);
      end
      runSeg(x, e, "R3", 1'b0, 0);
    end
  endtask

  task automatic testRandomFull();
    for (int t = 0; t < 6; t++) begin
      logic [N*W-1:0] x;
      for (int k = 0; k < N; k++) x[k*W +: W] = W'($urandom_range(P - 1, 0));
      runSeg(x, refConv(x), "R2", 1'b0, 0);
    end
  endtask

  task automatic testMaxValues();
    logic [N*W-1:0] x;
    for (int k = 0; k < N; k++) x[k*W +: W] = W'(P - 1);
    runSeg(x, refConv(x), "R4", 1'b0, 0);
  endtask

  task automatic testBusyIgnored();
    logic [N*W-1:0] x;
    for (int k = 0; k < N; k++) x[k*W +: W] = W'((k * 7 + 3) % P);
    runSeg(x, refConv(x), "R5", 1'b1, 0);
  endtask

  task automatic testHold();
    logic [N*W-1:0] x;
    for (int k = 0; k < N; k++) x[k*W +: W] = W'((k * 13 + 5) % P);
    runSeg(x, refConv(x), "R7", 1'b0, 6);
  endtask

  task automatic testBackToBack();
    for (int t = 0; t < 3; t++) begin
      logic [N*W-1:0] x;
      for (int k = 0; k < N; k++) x[k*W +: W] = W'((k + t * 11) % P);
      runSeg(x, refConv(x), "R8", 1'b0, 0);
    end
  endtask

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testImpulseAndZero();
    testLinear();
    testRandomFull();
    testMaxValues();
    testBusyIgnored();
    testHold();
    testBackToBack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule